// File: doc/BRIEF.md
# Boolean-Function Group Sequencer

This block carries out the bitwise logic instruction group of a 36-bit processor. When an instruction whose top three opcode bits are `100` is handed over with a start strobe, the block splits the remaining six bits into a 4-bit function code and a 2-bit destination mode. It then runs the needed accesses over a single shared memory port. The accumulators are the low sixteen words of that port's address space.

The first operand is always the selected accumulator. The second operand is either the effective address, zero-extended to a full word, or the memory word at that address. The 4-bit function code is the truth table of a two-input boolean function, so every one of the sixteen functions is available: clear, AND, XOR, OR, set-to-ones and the rest. The result goes to the accumulator, to memory, or to both, depending on the mode. A one-cycle done pulse marks the end of the instruction. Effective-address calculation happens upstream of this block.

Top module: `boolfn_seq`

## Requirements
- R1: A start strobe is accepted only when the block is idle and opcode[8:6] equals 3'b100. Any other opcode causes no memory access and no done pulse.
- R2: Each result bit i equals fn[2*a_i + b_i], where fn = opcode[5:2], a is the accumulator operand and b is the second operand. For example, 4'b1000 gives AND, 4'b0110 gives XOR, 4'b1110 gives OR, 4'b0000 gives all zeros and 4'b1111 gives all ones.
- R3: Mode opcode[1:0]=2'b01 uses {18'b0, ea} as the second operand. It performs exactly one read of the accumulator followed by one write of the result to the accumulator, and it never accesses address ea.
- R4: Mode 2'b00 reads address ea, then reads the accumulator, then writes the result to the accumulator only.
- R5: Mode 2'b10 reads address ea, then reads the accumulator, then writes the result to address ea only. The accumulator is left unchanged.
- R6: Mode 2'b11 reads address ea, then reads the accumulator, then writes the result to the accumulator, and finally writes the result to address ea.
- R7: Accumulator n is the memory word at address n, zero-extended to the address width.
- R8: Every access holds mem_req, mem_we, mem_addr and mem_wdata stable until mem_ready is sampled high. mem_we is only ever asserted together with mem_req.
- R9: done is high for exactly one cycle, which is the cycle right after the final write is accepted. No request is made in that cycle.
- R10: Start strobes and changes on opcode, ac_sel or ea while an instruction is in progress have no effect on that instruction and do not start another one.
- R11: While reset is asserted and in the first cycle after it is released, mem_req and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Instruction start strobe |
| opcode | input | 9 | Instruction opcode |
| ac_sel | input | 4 | Accumulator number |
| ea | input | 18 | Effective address |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | 18 | Access address |
| mem_wdata | output | 36 | Write data |
| mem_rdata | input | 36 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
A wrong state or a wrong mode decode shows up at the memory port as soon as the next access is issued. It appears as a wrong address, a wrong read/write flag, or an extra or missing access, so the access log of each instruction exposes it within a few cycles. A wrong function table or a wrong operand choice only appears at the write that carries the result. The bench therefore compares the memory contents after every instruction against a word-wide model. A stuck state appears as a done pulse that never arrives, and the per-instruction timeout catches it.

// File: rtl/boolfn_pkg.sv
package boolfn_pkg;

    localparam int WORD_W = 36;
    localparam int ADDR_W = WORD_W / 2;
    localparam int AC_W   = 4;
    localparam int OPC_W  = 9;
    localparam int FN_W   = 4;

    localparam logic [2:0] GROUP_CODE = 3'b100;

    typedef enum logic [1:0] {
        MODE_TO_AC = 2'b00,
        MODE_IMM   = 2'b01,
        MODE_TO_EA = 2'b10,
        MODE_BOTH  = 2'b11
    } dest_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_EA,
        ST_RD_AC,
        ST_WR_AC,
        ST_WR_EA
    } seq_state_t;

    typedef struct packed {
        logic [FN_W-1:0] fn;
        dest_mode_t      mode;
    } cmd_t;

    function automatic logic in_group(input logic [OPC_W-1:0] opc);
        return opc[OPC_W-1 -: 3] == GROUP_CODE;
    endfunction

    function automatic cmd_t decode_cmd(input logic [OPC_W-1:0] opc);
        cmd_t c;
        c.fn   = opc[5:2];
        c.mode = dest_mode_t'(opc[1:0]);
        return c;
    endfunction

endpackage

// File: rtl/boolfn_lut.sv
module boolfn_lut #(
    parameter int W    = boolfn_pkg::WORD_W,
    parameter int FN_W = boolfn_pkg::FN_W
) (
    input  logic [FN_W-1:0] table_bits,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = table_bits[{a[i], b[i]}];
    end
endmodule

// File: rtl/boolfn_ctrl.sv
module boolfn_ctrl
    import boolfn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_ok,
    input  dest_mode_t new_mode,
    input  dest_mode_t cur_mode,
    input  logic       mem_ready,
    output seq_state_t state,
    output logic       load_op,
    output logic       hold_en,
    output logic       result_en,
    output logic       done
);
    seq_state_t state_nxt;
    logic       finish;

    always_comb begin
        state_nxt = state;
        load_op   = 1'b0;
        hold_en   = 1'b0;
        result_en = 1'b0;
        finish    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_ok) begin
                    load_op   = 1'b1;
                    state_nxt = (new_mode == MODE_IMM) ? ST_RD_AC : ST_RD_EA;
                end
            end
            ST_RD_EA: begin
                if (mem_ready) begin
                    hold_en   = 1'b1;
                    state_nxt = ST_RD_AC;
                end
            end
            ST_RD_AC: begin
                if (mem_ready) begin
                    result_en = 1'b1;
                    state_nxt = (cur_mode == MODE_TO_EA) ? ST_WR_EA : ST_WR_AC;
                end
            end
            ST_WR_AC: begin
                if (mem_ready) begin
                    if (cur_mode == MODE_BOTH) begin
                        state_nxt = ST_WR_EA;
                    end else begin
                        state_nxt = ST_IDLE;
                        finish    = 1'b1;
                    end
                end
            end
            ST_WR_EA: begin
                if (mem_ready) begin
                    state_nxt = ST_IDLE;
                    finish    = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nxt;
            done  <= finish;
        end
    end
endmodule

// File: rtl/boolfn_port.sv
module boolfn_port
    import boolfn_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int ADDR_W = boolfn_pkg::ADDR_W,
    parameter int AC_W   = boolfn_pkg::AC_W
) (
    input  seq_state_t        state,
    input  logic [AC_W-1:0]   ac_q,
    input  logic [ADDR_W-1:0] ea_q,
    input  logic [W-1:0]      result_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [W-1:0]      mem_wdata
);
    localparam int AC_PAD = ADDR_W - AC_W;

    logic [ADDR_W-1:0] ac_addr;
    assign ac_addr   = {{AC_PAD{1'b0}}, ac_q};
    assign mem_wdata = result_q;

    always_comb begin
        mem_req  = 1'b1;
        mem_we   = 1'b0;
        mem_addr = ac_addr;
        unique case (state)
            ST_IDLE:  mem_req = 1'b0;
            ST_RD_EA: mem_addr = ea_q;
            ST_RD_AC: mem_addr = ac_addr;
            ST_WR_AC: mem_we = 1'b1;
            ST_WR_EA: begin
                mem_we   = 1'b1;
                mem_addr = ea_q;
            end
            default:  mem_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/boolfn_seq.sv
module boolfn_seq
    import boolfn_pkg::*;
#(
    parameter int W      = WORD_W,
    parameter int ADDR_W = boolfn_pkg::ADDR_W,
    parameter int AC_W   = boolfn_pkg::AC_W,
    parameter int OPC_W  = boolfn_pkg::OPC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [AC_W-1:0]   ac_sel,
    input  logic [ADDR_W-1:0] ea,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [W-1:0]      mem_wdata,
    input  logic [W-1:0]      mem_rdata,
    input  logic              mem_ready
);
    localparam int IMM_PAD = W - ADDR_W;

    seq_state_t        state;
    cmd_t              cmd_new, cmd_q;
    logic [AC_W-1:0]   ac_q;
    logic [ADDR_W-1:0] ea_q;
    logic [W-1:0]      hold_q, result_q, operand_b, lut_y;
    logic              start_ok, load_op, hold_en, result_en;

    assign cmd_new  = decode_cmd(opcode);
    assign start_ok = start && (state == ST_IDLE) && in_group(opcode);

    assign operand_b = (cmd_q.mode == MODE_IMM) ? {{IMM_PAD{1'b0}}, ea_q} : hold_q;

    boolfn_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start_ok  (start_ok),
        .new_mode  (cmd_new.mode),
        .cur_mode  (cmd_q.mode),
        .mem_ready (mem_ready),
        .state     (state),
        .load_op   (load_op),
        .hold_en   (hold_en),
        .result_en (result_en),
        .done      (done)
    );

    boolfn_lut #(.W(W)) u_lut (
        .table_bits (cmd_q.fn),
        .a          (mem_rdata),
        .b          (operand_b),
        .y          (lut_y)
    );

    boolfn_port #(.W(W), .ADDR_W(ADDR_W), .AC_W(AC_W)) u_port (
        .state     (state),
        .ac_q      (ac_q),
        .ea_q      (ea_q),
        .result_q  (result_q),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            ac_q     <= '0;
            ea_q     <= '0;
            hold_q   <= '0;
            result_q <= '0;
        end else begin
            if (load_op) begin
                cmd_q <= cmd_new;
                ac_q  <= ac_sel;
                ea_q  <= ea;
            end
            if (hold_en)   hold_q   <= mem_rdata;
            if (result_en) result_q <= lut_y;
        end
    end
endmodule

// File: rtl/boolfn_seq_chk.sv
module boolfn_seq_chk #(
    parameter int W      = boolfn_pkg::WORD_W,
    parameter int ADDR_W = boolfn_pkg::ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [W-1:0]      mem_wdata
);
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_req && !done)); // R11

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_NOREQ: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                     && $stable(mem_wdata))); // R8

    AST_WE_REQ: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req); // R8
endmodule

bind boolfn_seq boolfn_seq_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/test_boolfn_seq.sv
`timescale 1ns/1ps
module test_boolfn_seq;
    localparam int W = 36;
    localparam int AW = 18;
    localparam int MEMN = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [8:0]    opcode = '0;
    logic [3:0]    ac_sel = '0;
    logic [AW-1:0] ea = '0;
    logic          done, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_wdata;
    logic [W-1:0]  mem_rdata = '0;
    logic          mem_ready = 1'b0;

    always #4 clk = ~clk;

    boolfn_seq i_boolfn_seq (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .ac_sel(ac_sel),
        .ea(ea), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    logic [W-1:0]  mem [MEMN];
    logic [AW-1:0] log_addr [8];
    logic          log_we [8];
    int            log_n = 0;
    int            done_cnt = 0;
    int            total = 0;
    int            bad = 0;
    int            cycles = 0;
    int            wait_pct = 50;

    // memory model: grants at the falling edge, taken by the design at the next rising edge
    always @(negedge clk) begin
        cycles++;
        if (done) done_cnt++;
        mem_ready <= 1'b0;
        if (!rst && mem_req && ($urandom_range(0, 99) >= wait_pct)) begin
            if (log_n < 8) begin
                log_addr[log_n] = mem_addr;
                log_we[log_n]   = mem_we;
            end
            log_n++;
            if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            mem_rdata <= mem[mem_addr[7:0]];
            mem_ready <= 1'b1;
        end
    end

    function automatic logic [W-1:0] ref_fn(input logic [3:0] f, input logic [W-1:0] a,
                                            input logic [W-1:0] b);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = f[{a[i], b[i]}];
        return r;
    endfunction

    task automatic check(input string req, input logic ok, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_done(output logic got);
        got = 1'b0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (done) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_op(input logic [3:0] f, input logic [1:0] md, input logic [3:0] ac,
                          input logic [AW-1:0] e, input logic disturb);
        logic [W-1:0]  a, b, r, exp_ac, exp_e, pre_ac;
        logic [AW-1:0] xa [4];
        logic          xw [4];
        int            xn, d0;
        logic          got;
        string         rq;
        rq = (md == 2'b01) ? "R3" : (md == 2'b00) ? "R4" : (md == 2'b10) ? "R5" : "R6";
        pre_ac = mem[ac];
        a = mem[ac];
        b = (md == 2'b01) ? {{(W-AW){1'b0}}, e} : mem[e[7:0]];
        r = ref_fn(f, a, b);
        exp_ac = (md == 2'b10) ? a : r;
        exp_e  = (md == 2'b10 || md == 2'b11) ? r : mem[e[7:0]];
        if (md != 2'b01 && e[7:0] == {4'b0, ac} && md != 2'b10) exp_e = r;
        if (md == 2'b10 && e[7:0] == {4'b0, ac}) exp_ac = r;
        case (md)
            2'b01: begin xn = 2; xa[0] = AW'(ac); xw[0] = 0; xa[1] = AW'(ac); xw[1] = 1; end
            2'b00: begin xn = 3; xa[0] = e; xw[0] = 0; xa[1] = AW'(ac); xw[1] = 0;
                         xa[2] = AW'(ac); xw[2] = 1; end
            2'b10: begin xn = 3; xa[0] = e; xw[0] = 0; xa[1] = AW'(ac); xw[1] = 0;
                         xa[2] = e; xw[2] = 1; end
            default: begin xn = 4; xa[0] = e; xw[0] = 0; xa[1] = AW'(ac); xw[1] = 0;
                           xa[2] = AW'(ac); xw[2] = 1; xa[3] = e; xw[3] = 1; end
        endcase
        log_n = 0;
        d0 = done_cnt;
        @(negedge clk);
        opcode = {3'b100, f, md}; ac_sel = ac; ea = e; start = 1'b1;
        @(negedge clk);
        if (disturb) begin
            // R10: strobe held with other fields while busy
            opcode = {3'b100, ~f, ~md}; ac_sel = ~ac; ea = ~e;
            @(negedge clk);
        end
        start = 1'b0;
        wait_done(got);
        check("R9 done", got, 64'(got), 64'd1);
        check({rq, " access count"}, log_n == xn, 64'(log_n), 64'(xn));
        for (int i = 0; i < xn && i < log_n; i++)
            check({rq, " R7 access"}, log_addr[i] == xa[i] && log_we[i] == xw[i],
                  {45'b0, log_we[i], log_addr[i]}, {45'b0, xw[i], xa[i]});
        check({rq, " R2 acc value"}, mem[ac] == exp_ac, 64'(mem[ac]), 64'(exp_ac));
        if (md != 2'b01)
            check({rq, " R2 mem value"}, mem[e[7:0]] == exp_e, 64'(mem[e[7:0]]), 64'(exp_e));
        @(negedge clk);
        check("R9 one-cycle done", !done && !mem_req, {62'b0, done, mem_req}, 64'd0);
        for (int i = 0; i < 4; i++) @(negedge clk);
        check("R10 no extra op", log_n == xn && done_cnt == d0 + 1,
              64'(done_cnt - d0), 64'd1);
        if (pre_ac == a) begin end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < MEMN; i++) mem[i] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        check("R11 reset quiet", !mem_req && !done, {62'b0, mem_req, done}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 after reset", !mem_req && !done, {62'b0, mem_req, done}, 64'd0);

        // R1: opcode outside the group
        log_n = 0;
        opcode = 9'b101_0110_00; ac_sel = 4'd3; ea = 18'd40; start = 1'b1;
        @(negedge clk);
        opcode = 9'b011_1110_11;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        check("R1 ignored opcode", log_n == 0 && done_cnt == 0, 64'(log_n), 64'd0);

        // directed: named functions across modes
        wait_pct = 0;
        run_op(4'b0000, 2'b01, 4'd1, 18'h3ffff, 1'b0); // R2 clear, R3
        run_op(4'b1111, 2'b00, 4'd2, 18'd100, 1'b0);   // R2 set, R4
        run_op(4'b1000, 2'b10, 4'd3, 18'd200, 1'b0);   // R2 AND, R5
        wait_pct = 60;
        run_op(4'b0110, 2'b11, 4'd4, 18'd77, 1'b0);    // R2 XOR, R6
        run_op(4'b1110, 2'b01, 4'd15, 18'h2a5a5, 1'b0); // R2 OR, R3 upper bits of ea
        run_op(4'b0110, 2'b11, 4'd9, 18'd9, 1'b0);     // R6 ea aliases accumulator
        run_op(4'b1000, 2'b00, 4'd5, 18'd120, 1'b1);   // R10
        run_op(4'b0110, 2'b01, 4'd6, 18'd5, 1'b1);     // R10 shortest op

        for (int n = 0; n < 60; n++) begin
            logic [1:0] md;
            wait_pct = $urandom_range(0, 70);
            md = 2'($urandom_range(0, 3));
            run_op(4'($urandom), md, 4'($urandom),
                   (md == 2'b01) ? AW'($urandom) : AW'($urandom_range(0, MEMN - 1)),
                   ($urandom_range(0, 3) == 0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule